// File: doc/BRIEF.md
# Delayed autocorrelation timing detector

This block finds the coarse start of an OFDM frame by spotting a preamble built from identical back-to-back parts. Every incoming complex sample is multiplied by the conjugate of the sample received 64 samples later. This lag is the repetition period. A 64-sample running sum of those products forms the correlation P. A 64-sample running sum of the newest samples' power forms the energy R. Both sums are updated with constant work per sample: the newest term is added and the term that leaves the window is subtracted.

The squared correlation magnitude is compared against a programmable fraction of the squared energy. The product of the first qualifying output opens a plateau. Because the metric is flat across the repeated region, a single maximum is not used. The plateau is closed only after a fixed run of below-threshold outputs, and the index of the first sample in that run is reported as the plateau end. The raw P components are exposed so that a later stage can take their phase for fractional frequency offset estimation.

Samples arrive on `valid_i`. Gaps between samples are allowed. Each accepted sample produces exactly one output beat on `valid_o`, tagged with its sample index.

Top module: `acorr_timing_det`

## Requirements
- R1: For the output with index n, `corr_re_o`/`corr_im_o` equal the exact sum over the 64 newest products r(k-64)·conj(r(k)), k = n-63..n. Samples before reset count as zero.
- R2: For index n, `energy_o` equals the exact sum of |r(k)|² for k = n-63..n. It is never negative.
- R3: The sums stay exact over an arbitrarily long stream of full-scale samples, including -2048 on both rails, with no drift or wrap.
- R4: `above_o` is 1 exactly when (re²+im²)·256 > thr·energy², where `thr_i` is an unsigned 9-bit value and 256 means 1.0. The comparison is strict, so equality gives 0.
- R5: `detect_o` rises on the first output beat with `above_o`=1 while no plateau is open.
- R6: An open plateau closes only after 8 consecutive below-threshold beats. A shorter below run followed by an above beat leaves it open.
- R7: On the closing beat `end_o` pulses for one cycle, `detect_o` falls, and `end_idx_o` takes the index of the first beat of the closing run. `end_idx_o` is held at all other times.
- R8: An output beat appears two clock cycles after the edge that samples `valid_i`=1. `idx_o` counts accepted samples from 0 after reset. Idle cycles between samples do not change any result.
- R9: Reset clears all outputs, sums and sample history.
- R10: With noise, then four identical 64-sample fragments rotated by π/4 per fragment, then noise: detection rises inside the repeated region, the end index falls within -8..+40 of the last preamble sample, and P inside the plateau has angle near -π/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| i_i | input | DW | In-phase sample, signed |
| q_i | input | DW | Quadrature sample, signed |
| thr_i | input | TF+1 | Threshold fraction, unsigned, 2^TF = 1.0 |
| valid_o | output | 1 | Output beat strobe |
| idx_o | output | IDX_W | Index of the newest sample in the window |
| corr_re_o | output | ACC_W | Correlation sum, real part |
| corr_im_o | output | ACC_W | Correlation sum, imaginary part |
| energy_o | output | ACC_W | Energy sum |
| above_o | output | 1 | Metric above threshold for this beat |
| detect_o | output | 1 | Plateau open |
| end_o | output | 1 | One-cycle pulse when the plateau closes |
| end_idx_o | output | IDX_W | Index of the first sample of the closing run |

## Verification
The assertions assume that `valid_i` is low while reset is held. They also assume that `thr_i` changes only while no sample is in flight, since the compare stage reads it two cycles after the sample is taken. The stimulus holds the threshold constant within each segment. It only changes the threshold after at least five idle cycles, and it keeps every sample within the signed 12-bit range. A golden model computes the exact sums directly over the stored history and mirrors the plateau rule, and every output beat is compared against it. Gaps in `valid_i` are drawn pseudo-randomly, so that output alignment follows `idx_o` rather than cycle counts.

// File: rtl/acorr_pkg.sv
package acorr_pkg;
  typedef enum logic {ST_IDLE, ST_PLAT} plat_state_e;
  localparam int LANE_RE = 0;
  localparam int LANE_IM = 1;
  localparam int LANE_EN = 2;
  localparam int N_LANES = 3;
endpackage

// File: rtl/acorr_delay.sv
module acorr_delay #(
  parameter int W     = 24,
  parameter int DEPTH = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] ptr_q;

  // slot at ptr holds the entry written DEPTH enables ago
  assign dout_o = mem_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (en_i) begin
      mem_q[ptr_q] <= din_i;
      ptr_q <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/acorr_window.sv
module acorr_window #(
  parameter int IN_W  = 25,
  parameter int ACC_W = 31
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  add_i,
  input  logic signed [IN_W-1:0]  sub_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_q + ACC_W'(add_i) - ACC_W'(sub_i);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/acorr_plateau.sv
module acorr_plateau
  import acorr_pkg::*;
#(
  parameter int HOLD  = 8,
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             above_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             detect_o,
  output logic             end_o,
  output logic [IDX_W-1:0] end_idx_o
);
  localparam int CW = $clog2(HOLD + 1);

  plat_state_e      state_q;
  logic [CW-1:0]    low_cnt_q;
  logic [IDX_W-1:0] fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      low_cnt_q <= '0;
      fall_q    <= '0;
      end_o     <= 1'b0;
      end_idx_o <= '0;
    end else begin
      end_o <= 1'b0;
      if (en_i) begin
        unique case (state_q)
          ST_IDLE: if (above_i) begin
            state_q   <= ST_PLAT;
            low_cnt_q <= '0;
          end
          ST_PLAT: if (above_i) begin
            low_cnt_q <= '0;
          end else begin
            if (low_cnt_q == '0) fall_q <= idx_i;
            if (low_cnt_q == CW'(HOLD - 1)) begin
              state_q   <= ST_IDLE;
              end_o     <= 1'b1;
              end_idx_o <= (low_cnt_q == '0) ? idx_i : fall_q;
              low_cnt_q <= '0;
            end else begin
              low_cnt_q <= low_cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign detect_o = (state_q == ST_PLAT);

  p_rise_on_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detect_o) |-> $past(en_i && above_i))
    else $error("plateau opened without an above beat");

  p_end_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (!detect_o && $past(detect_o) && $past(en_i && !above_i)))
    else $error("end pulse without closing a plateau");

  p_end_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o)
    else $error("end pulse longer than one cycle");

  p_end_idx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_o |-> $stable(end_idx_o))
    else $error("end index moved without an end pulse");
endmodule

// File: rtl/acorr_timing_det.sv
module acorr_timing_det
  import acorr_pkg::*;
#(
  parameter int DW    = 12,
  parameter int LAG   = 64,
  parameter int WIN   = 64,
  parameter int TF    = 8,
  parameter int HOLD  = 8,
  parameter int IDX_W = 16,
  localparam int PW    = 2 * DW + 1,
  localparam int ACC_W = PW + $clog2(WIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [DW-1:0]    i_i,
  input  logic signed [DW-1:0]    q_i,
  input  logic [TF:0]             thr_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic signed [ACC_W-1:0] corr_re_o,
  output logic signed [ACC_W-1:0] corr_im_o,
  output logic signed [ACC_W-1:0] energy_o,
  output logic                    above_o,
  output logic                    detect_o,
  output logic                    end_o,
  output logic [IDX_W-1:0]        end_idx_o
);
  localparam int CMP_W = 2 * ACC_W + TF + 1;

  // stage 0: sample counter and lag line
  logic [IDX_W-1:0] cnt_q;
  logic [2*DW-1:0]  dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end

  acorr_delay #(.W(2 * DW), .DEPTH(LAG)) u_lag (
    .clk_i, .rst_ni, .en_i(valid_i), .din_i({i_i, q_i}), .dout_o(dly)
  );

  logic signed [DW-1:0] yr, yi;
  logic signed [PW-1:0] yr_e, yi_e, xr_e, xi_e;
  logic signed [PW-1:0] prod_c [N_LANES];

  assign yr   = dly[2*DW-1:DW];
  assign yi   = dly[DW-1:0];
  assign yr_e = PW'(yr);
  assign yi_e = PW'(yi);
  assign xr_e = PW'(i_i);
  assign xi_e = PW'(q_i);

  // older sample times conjugate of newer sample, and newer-sample power
  always_comb begin
    prod_c[LANE_RE] = yr_e * xr_e + yi_e * xi_e;
    prod_c[LANE_IM] = yi_e * xr_e - yr_e * xi_e;
    prod_c[LANE_EN] = xr_e * xr_e + xi_e * xi_e;
  end

  // stage 1: registered products
  logic                 s1_v;
  logic [IDX_W-1:0]     s1_idx;
  logic signed [PW-1:0] prod_q [N_LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_idx <= '0;
      for (int l = 0; l < N_LANES; l++) prod_q[l] <= '0;
    end else begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_idx <= cnt_q;
        for (int l = 0; l < N_LANES; l++) prod_q[l] <= prod_c[l];
      end
    end
  end

  // stage 2: window line and recursive sums
  logic [N_LANES*PW-1:0]   pk_in, pk_old;
  logic signed [PW-1:0]    old_l [N_LANES];
  logic signed [ACC_W-1:0] acc   [N_LANES];

  acorr_delay #(.W(N_LANES * PW), .DEPTH(WIN)) u_win_line (
    .clk_i, .rst_ni, .en_i(s1_v), .din_i(pk_in), .dout_o(pk_old)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign pk_in[l*PW +: PW] = prod_q[l];
    assign old_l[l]          = pk_old[l*PW +: PW];
    acorr_window #(.IN_W(PW), .ACC_W(ACC_W)) u_sum (
      .clk_i, .rst_ni, .en_i(s1_v), .add_i(prod_q[l]), .sub_i(old_l[l]), .acc_o(acc[l])
    );
  end

  logic             s2_v;
  logic [IDX_W-1:0] s2_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v   <= 1'b0;
      s2_idx <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) s2_idx <= s1_idx;
    end
  end

  // metric compare: |P|^2 * 2^TF > thr * R^2
  logic signed [CMP_W-1:0] pr_x, pi_x, en_x, thr_x, lhs, rhs;
  logic                    above_c;

  assign pr_x  = CMP_W'(acc[LANE_RE]);
  assign pi_x  = CMP_W'(acc[LANE_IM]);
  assign en_x  = CMP_W'(acc[LANE_EN]);
  assign thr_x = {{(CMP_W - TF - 1){1'b0}}, thr_i};
  assign lhs   = (pr_x * pr_x + pi_x * pi_x) <<< TF;
  assign rhs   = thr_x * (en_x * en_x);
  assign above_c = (lhs > rhs);

  // stage 3: outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      idx_o     <= '0;
      corr_re_o <= '0;
      corr_im_o <= '0;
      energy_o  <= '0;
      above_o   <= 1'b0;
    end else begin
      valid_o <= s2_v;
      if (s2_v) begin
        idx_o     <= s2_idx;
        corr_re_o <= acc[LANE_RE];
        corr_im_o <= acc[LANE_IM];
        energy_o  <= acc[LANE_EN];
        above_o   <= above_c;
      end
    end
  end

  acorr_plateau #(.HOLD(HOLD), .IDX_W(IDX_W)) u_plat (
    .clk_i, .rst_ni, .en_i(s2_v), .above_i(above_c), .idx_i(s2_idx),
    .detect_o, .end_o, .end_idx_o
  );

  p_energy_nonneg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !energy_o[ACC_W-1])
    else $error("energy sum went negative");

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3))
    else $error("output beat without a sample two cycles earlier");

  p_detect_tracks_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detect_o) |-> (valid_o && above_o))
    else $error("detect rose on a below beat");

  p_end_below_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (valid_o && !above_o))
    else $error("plateau closed on an above beat");
endmodule

// File: tb/acorr_timing_det_tb_top.sv
module acorr_timing_det_tb_top;
  localparam int DW = 12, TF = 8, IDX_W = 16, ACC_W = 2 * DW + 1 + 6;
  localparam int NS = 4096;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic signed [DW-1:0] i_i = '0, q_i = '0;
  logic [TF:0] thr_i = 9'd192;
  logic valid_o, above_o, detect_o, end_o;
  logic [IDX_W-1:0] idx_o, end_idx_o;
  logic signed [ACC_W-1:0] corr_re_o, corr_im_o, energy_o;

  always #2 clk = ~clk;

  acorr_timing_det dut_i (
    .clk_i(clk), .rst_ni, .valid_i, .i_i, .q_i, .thr_i,
    .valid_o, .idx_o, .corr_re_o, .corr_im_o, .energy_o,
    .above_o, .detect_o, .end_o, .end_idx_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int si [NS];
  int sq [NS];
  int thr_at [NS];
  int n_fed = 0, exp_next = 0;
  string sum_req = "R1";
  // golden plateau state
  bit g_st = 0; int g_cnt = 0, g_fall = 0, g_end_idx = 0;
  // scenario bookkeeping
  int first_det = -1, end_cnt = 0, last_end = -1, rises = 0, dip_above = 0;
  int probe_idx = -1; longint probe_re = 0, probe_im = 0;
  bit prev_det = 0;
  int unsigned rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int smp_i(int k); return (k < 0) ? 0 : si[k]; endfunction
  function automatic int smp_q(int k); return (k < 0) ? 0 : sq[k]; endfunction

  task automatic gold(input int n, output longint pre, output longint pim, output longint en);
    pre = 0; pim = 0; en = 0;
    for (int m = 0; m < 64; m++) begin
      longint yr, yi, xr, xi;
      yr = smp_i(n - 127 + m); yi = smp_q(n - 127 + m);
      xr = smp_i(n - 63 + m);  xi = smp_q(n - 63 + m);
      pre += yr * xr + yi * xi;
      pim += yi * xr - yr * xi;
      en  += xr * xr + xi * xi;
    end
  endtask

  function automatic bit above_ref(longint pre, longint pim, longint en, int thr);
    logic signed [127:0] a, b, c, t;
    a = pre; b = pim; c = en; t = thr;
    return ((a * a + b * b) * 256) > (t * c * c);
  endfunction

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      longint pre, pim, en; bit ab, e_end; int n;
      n = exp_next;
      chk(idx_o == IDX_W'(n), "R8", "output index", idx_o, n);
      gold(n, pre, pim, en);
      ab = above_ref(pre, pim, en, thr_at[n]);
      chk(longint'(corr_re_o) == pre, sum_req, "corr re", corr_re_o, pre);
      chk(longint'(corr_im_o) == pim, sum_req, "corr im", corr_im_o, pim);
      chk(longint'(energy_o) == en, (sum_req == "R3") ? "R3" : "R2", "energy", energy_o, en);
      chk(above_o == ab, "R4", "above", above_o, ab);
      e_end = 0;
      if (!g_st) begin
        if (ab) begin g_st = 1; g_cnt = 0; end
      end else if (ab) g_cnt = 0;
      else begin
        if (g_cnt == 0) g_fall = n;
        if (g_cnt == 7) begin g_st = 0; e_end = 1; g_end_idx = g_fall; g_cnt = 0; end
        else g_cnt++;
      end
      chk(detect_o == g_st, "R5", "detect", detect_o, g_st);
      chk(end_o == e_end, "R6", "end pulse", end_o, e_end);
      chk(end_idx_o == IDX_W'(g_end_idx), "R7", "end index", end_idx_o, g_end_idx);
      if (detect_o && !prev_det) begin rises++; if (first_det < 0) first_det = n; end
      if (end_o) begin end_cnt++; last_end = end_idx_o; end
      if (n >= 200 && n <= 204 && above_o) dip_above++;
      if (n == probe_idx) begin probe_re = corr_re_o; probe_im = corr_im_o; end
      prev_det = detect_o;
      exp_next++;
    end else if (rst_ni) begin
      chk(end_o == 1'b0, "R7", "end pulse off-beat", end_o, 0);
    end
  end

  task automatic send(input int a, input int b);
    @(negedge clk);
    valid_i = 1'b1; i_i = DW'(a); q_i = DW'(b);
    si[n_fed] = a; sq[n_fed] = b; thr_at[n_fed] = thr_i;
    n_fed++;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(negedge clk); valid_i = 1'b0; end
  endtask

  task automatic maybe_gap();
    if ((nxt() & 3) == 0) idle(1 + (nxt() & 1));
  endtask

  task automatic noise_smp();
    int a, b;
    a = int'(nxt() % 2048) - 1024; b = int'(nxt() % 2048) - 1024;
    send(a, b);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; valid_i = 1'b0;
    idle(3);
    n_fed = 0; exp_next = 0; g_st = 0; g_cnt = 0; g_fall = 0; g_end_idx = 0;
    first_det = -1; end_cnt = 0; last_end = -1; rises = 0; dip_above = 0;
    probe_idx = -1; prev_det = 0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset();
    idle(2);
    chk(valid_o == 0 && detect_o == 0 && above_o == 0, "R9", "flags after reset",
        {valid_o, detect_o, above_o}, 0);
    chk(corr_re_o == 0 && corr_im_o == 0 && energy_o == 0, "R9", "sums after reset",
        energy_o, 0);
    chk(end_o == 0 && end_idx_o == 0, "R9", "end after reset", end_idx_o, 0);

    // noise only, gapped: no plateau (R5, R8)
    thr_i = 9'd192; sum_req = "R1";
    for (int k = 0; k < 400; k++) begin noise_smp(); maybe_gap(); end
    idle(6);
    chk(rises == 0, "R5", "no detect on noise", rises, 0);
    chk(exp_next == n_fed, "R8", "beats per sample", exp_next, n_fed);

    // R10: noise, rotated repeated preamble, noise; R9 history cleared
    do_reset();
    thr_i = 9'd192;
    probe_idx = 300 + 200;
    for (int k = 0; k < 300; k++) begin noise_smp(); maybe_gap(); end
    for (int p = 0; p < 256; p++) begin
      real th; int f;
      f = p % 64;
      th = 2.0 * 3.14159265358979 * real'((f * f * 7 + 3 * f) % 64) / 64.0
         + (3.14159265358979 / 4.0) * real'(p) / 64.0;
      send(int'(1000.0 * $cos(th)), int'(1000.0 * $sin(th)));
      maybe_gap();
    end
    for (int k = 0; k < 300; k++) begin noise_smp(); maybe_gap(); end
    idle(6);
    chk(first_det >= 364 && first_det <= 555, "R10", "detect inside region", first_det, 364);
    chk(end_cnt == 1, "R10", "single plateau", end_cnt, 1);
    chk(last_end >= 547 && last_end <= 595, "R10", "end near region end", last_end, 555);
    chk(probe_re > 0 && probe_im < 0, "R10", "phase quadrant", probe_im, -probe_re);
    chk((probe_re + probe_im) < probe_re / 8 && (probe_re + probe_im) > -probe_re / 8,
        "R10", "phase near -pi/4", probe_re + probe_im, 0);

    // R4/R6/R7: constant input, threshold steps while idle
    do_reset();
    thr_i = 9'd128;
    for (int k = 0; k < 200; k++) send(300, 400);
    idle(5); thr_i = 9'd256;
    for (int k = 0; k < 5; k++) send(300, 400);
    idle(5); thr_i = 9'd128;
    for (int k = 0; k < 10; k++) send(300, 400);
    idle(5); thr_i = 9'd256;
    for (int k = 0; k < 10; k++) send(300, 400);
    idle(6);
    chk(first_det == 109, "R5", "first above beat", first_det, 109);
    chk(dip_above == 0, "R4", "equality is not above", dip_above, 0);
    chk(end_cnt == 1, "R6", "short dip ignored", end_cnt, 1);
    chk(last_end == 215, "R7", "end index of closing run", last_end, 215);

    // R3: long full-scale stream, no gaps
    do_reset();
    thr_i = 9'd192; sum_req = "R3";
    for (int k = 0; k < 3000; k++) begin
      if ((k % 200) < 70) send(-2048, -2048);
      else send(int'(nxt() % 4096) - 2048, int'(nxt() % 4096) - 2048);
    end
    idle(6);
    chk(exp_next == 3000, "R3", "all beats seen", exp_next, 3000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule